// File: doc/BRIEF.md
# Right Shift and Rotate Unit with Condition Flags

This unit performs the one-bit right shifts and the rotate of an 8-bit accumulator machine. It also performs the 16-bit logical right shift of the double accumulator. It takes an operand, an operation code, a width select and the current four-bit condition nibble. It produces the shifted value and a new nibble holding negative, zero, overflow and carry. The half-carry and interrupt-mask bits sit outside this nibble and never reach the unit.

After every shift or rotate, the unit clears all four flags and then computes them again. Carry takes the bit that leaves at the bottom. Overflow is derived from the new sign and the new carry: it is their exclusive-OR. The previous overflow is never kept.

The computation is combinational. A single register stage captures the result whenever the valid input is high, and reset clears that stage. Opcode decoding and memory sequencing belong to the surrounding core.

Top module: `shr_unit`

## Requirements
- R1: A synchronous reset drives `result_q` and `cc_q` to zero.
- R2: While `in_valid` is low, `result_q` and `cc_q` keep their values. Both registers update on the rising clock edge that sees `in_valid` high, so the outputs follow the inputs one cycle later.
- R3: With `wide_sel`=0 and `op_sel`=2'b00 (logical), `result_q[7:0]` is operand bits 7..1 with 0 inserted at bit 7, and `result_q[15:8]` is 0. The negative flag is 0.
- R4: With `wide_sel`=0 and `op_sel`=2'b01 (arithmetic), bit 7 of the result equals operand bit 7, and bits 6..0 are operand bits 7..1.
- R5: With `wide_sel`=0 and `op_sel`=2'b10 (rotate), bit 7 of the result is the incoming carry, `cc_in[0]`, and bits 6..0 are operand bits 7..1.
- R6: For every shift and rotate, the new carry, `cc_q[0]`, equals operand bit 0 before the shift.
- R7: For every shift and rotate, the new overflow, `cc_q[1]`, equals the new negative flag `cc_q[3]` XOR the new carry `cc_q[0]`, whatever `cc_in[1]` was.
- R8: On the 8-bit path, negative (`cc_q[3]`) is result bit 7, and zero (`cc_q[2]`) is set exactly when result bits 7..0 are all 0. Operand bits 15..8 are ignored.
- R9: With `wide_sel`=1 and `op_sel`=2'b00, the unit shifts all 16 bits right and inserts 0 at bit 15. Zero is set only when all 16 result bits are 0, and negative is 0.
- R10: `op_sel`=2'b11 is reserved. It makes `result_q` the full 16-bit operand unchanged and `cc_q` equal to `cc_in`.
- R11: With `wide_sel`=1 and `op_sel` equal to 2'b01 or 2'b10, the unit passes the operand and `cc_in` through unchanged, as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture enable for the output stage |
| wide_sel | input | 1 | 0: 8-bit path, 1: 16-bit path |
| op_sel | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved |
| operand | input | 16 | Value to shift; only bits 7..0 are used on the 8-bit path |
| cc_in | input | 4 | Current flags: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |
| result_q | output | 16 | Registered shifted value |
| cc_q | output | 4 | Registered updated flags, same bit layout as `cc_in` |

## Verification
The hardest cases to reach are the ones where the overflow rule disagrees with a naive model.

- A rotate with the carry set moves a 1 into the sign while the shifted-out bit is also 1. The result therefore has overflow clear even though the incoming overflow was set.
- An arithmetic shift of 0x80 has the sign set and the carry clear, so overflow must be set.
- A wide shift whose low result byte is zero but whose high byte is not must leave the zero flag clear.

The vector table places each of these patterns under an incoming flag nibble that has overflow and the other flags set opposite to the expected outcome. A stale overflow or an 8-bit zero test therefore shows up at the ports.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        SHR_LOGIC  = 2'b00,
        SHR_ARITH  = 2'b01,
        SHR_ROTATE = 2'b10,
        SHR_RSVD   = 2'b11
    } shr_op_e;

    localparam int CC_W   = 4;
    localparam int CC_C   = 0;
    localparam int CC_V   = 1;
    localparam int CC_Z   = 2;
    localparam int CC_N   = 3;

    // Build the flag nibble; overflow is derived from the new sign and carry.
    function automatic logic [CC_W-1:0] make_cc(input logic n, input logic z, input logic c);
        logic [CC_W-1:0] f;
        f        = '0;
        f[CC_N]  = n;
        f[CC_Z]  = z;
        f[CC_V]  = n ^ c;
        f[CC_C]  = c;
        return f;
    endfunction

endpackage

// File: rtl/shr_narrow.sv
module shr_narrow
    import shr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  shr_op_e           op,
    input  logic              cin,
    output logic [DATA_W-1:0] r,
    output logic              n,
    output logic              z,
    output logic              c
);
    localparam int MSB = DATA_W - 1;

    logic fill;

    always_comb begin
        case (op)
            SHR_ARITH:  fill = a[MSB];
            SHR_ROTATE: fill = cin;
            default:    fill = 1'b0;
        endcase
        r = {fill, a[MSB:1]};
        n = r[MSB];
        z = (r == '0);
        c = a[0];
    end

endmodule

// File: rtl/shr_wide.sv
module shr_wide #(
    parameter int WIDE_W = 16
) (
    input  logic [WIDE_W-1:0] a,
    output logic [WIDE_W-1:0] r,
    output logic              z,
    output logic              c
);
    genvar i;
    generate
        for (i = 0; i < WIDE_W - 1; i++) begin : g_bit
            assign r[i] = a[i+1];
        end
    endgenerate
    assign r[WIDE_W-1] = 1'b0;
    assign z           = (r == '0);
    assign c           = a[0];

endmodule

// File: rtl/shr_unit.sv
module shr_unit
    import shr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_sel,
    input  logic [1:0]        op_sel,
    input  logic [WIDE_W-1:0] operand,
    input  logic [CC_W-1:0]   cc_in,
    output logic [WIDE_W-1:0] result_q,
    output logic [CC_W-1:0]   cc_q
);
    typedef struct packed {
        logic [WIDE_W-1:0] res;
        logic [CC_W-1:0]   cc;
    } stage_t;

    stage_t  stage_d, stage_q;
    shr_op_e op_e;

    logic [DATA_W-1:0] nar_r;
    logic              nar_n, nar_z, nar_c;
    logic [WIDE_W-1:0] wid_r;
    logic              wid_z, wid_c;

    assign op_e = shr_op_e'(op_sel);

    shr_narrow #(.DATA_W(DATA_W)) u_narrow (
        .a   (operand[DATA_W-1:0]),
        .op  (op_e),
        .cin (cc_in[CC_C]),
        .r   (nar_r),
        .n   (nar_n),
        .z   (nar_z),
        .c   (nar_c)
    );

    shr_wide #(.WIDE_W(WIDE_W)) u_wide (
        .a (operand),
        .r (wid_r),
        .z (wid_z),
        .c (wid_c)
    );

    always_comb begin
        stage_d = stage_q;
        if (in_valid) begin
            // pass-through default: reserved op and wide non-logical ops
            stage_d.res = operand;
            stage_d.cc  = cc_in;
            if (wide_sel) begin
                if (op_e == SHR_LOGIC) begin
                    stage_d.res = wid_r;
                    stage_d.cc  = make_cc(1'b0, wid_z, wid_c);
                end
            end else if (op_e != SHR_RSVD) begin
                stage_d.res = {{DATA_W{1'b0}}, nar_r};
                stage_d.cc  = make_cc(nar_n, nar_z, nar_c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign result_q = stage_q.res;
    assign cc_q     = stage_q.cc;

endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              wide_sel,
    input logic [1:0]        op_sel,
    input logic [WIDE_W-1:0] operand,
    input logic [3:0]        cc_in,
    input logic [WIDE_W-1:0] result_q,
    input logic [3:0]        cc_q
);
    logic shifting;
    assign shifting = in_valid && (op_sel != 2'b11) && !(wide_sel && op_sel != 2'b00);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (result_q == '0 && cc_q == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result_q) && $stable(cc_q)));

    p_lsr_no_neg_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b00) |=> !cc_q[3]);

    p_asr_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel && op_sel == 2'b01) |=> result_q[DATA_W-1] == $past(operand[DATA_W-1]));

    p_ror_msb_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel && op_sel == 2'b10) |=> result_q[DATA_W-1] == $past(cc_in[0]));

    p_carry_out_r6: assert property (@(posedge clk) disable iff (rst)
        shifting |=> cc_q[0] == $past(operand[0]));

    p_v_is_n_xor_c_r7: assert property (@(posedge clk) disable iff (rst)
        shifting |=> cc_q[1] == (cc_q[3] ^ cc_q[0]));

    p_wide_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_sel && op_sel == 2'b00) |=> cc_q[2] == (result_q == '0));

    p_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |=> (result_q == $past(operand) && cc_q == $past(cc_in)));

    p_wide_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_sel && op_sel != 2'b00) |=> (result_q == $past(operand) && cc_q == $past(cc_in)));

endmodule

bind shr_unit shr_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .wide_sel (wide_sel),
    .op_sel   (op_sel),
    .operand  (operand),
    .cc_in    (cc_in),
    .result_q (result_q),
    .cc_q     (cc_q)
);

// File: tb/shr_unit_test.sv
`timescale 1ns/1ps
module shr_unit_test;
    localparam int NVEC = 19;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        wide_sel;
    logic [1:0]  op_sel;
    logic [15:0] operand;
    logic [3:0]  cc_in;
    logic [15:0] result_q;
    logic [3:0]  cc_q;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shr_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_sel(wide_sel),
        .op_sel(op_sel), .operand(operand), .cc_in(cc_in),
        .result_q(result_q), .cc_q(cc_q)
    );

    // {wide, op[1:0], operand[15:0], cc_in[3:0], exp_res[15:0], exp_cc[3:0]}; cc = N Z V C
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 16'h0081, 4'h0, 16'h0040, 4'h3},
        {1'b0, 2'b00, 16'h0001, 4'hF, 16'h0000, 4'h7},
        {1'b0, 2'b00, 16'h0002, 4'hF, 16'h0001, 4'h0},
        {1'b0, 2'b00, 16'hAB02, 4'h0, 16'h0001, 4'h0},
        {1'b0, 2'b01, 16'h0080, 4'h0, 16'h00C0, 4'hA},
        {1'b0, 2'b01, 16'h0081, 4'h2, 16'h00C0, 4'h9},
        {1'b0, 2'b01, 16'h0001, 4'h0, 16'h0000, 4'h7},
        {1'b0, 2'b01, 16'h007E, 4'hF, 16'h003F, 4'h0},
        {1'b0, 2'b10, 16'h0001, 4'h3, 16'h0080, 4'h9},
        {1'b0, 2'b10, 16'h0001, 4'h0, 16'h0000, 4'h7},
        {1'b0, 2'b10, 16'h00FE, 4'h1, 16'h00FF, 4'hA},
        {1'b0, 2'b10, 16'hFF00, 4'hE, 16'h0000, 4'h4},
        {1'b1, 2'b00, 16'h8001, 4'h0, 16'h4000, 4'h3},
        {1'b1, 2'b00, 16'h0200, 4'hF, 16'h0100, 4'h0},
        {1'b1, 2'b00, 16'h0001, 4'h8, 16'h0000, 4'h7},
        {1'b1, 2'b00, 16'h0100, 4'h0, 16'h0080, 4'h0},
        {1'b0, 2'b11, 16'h1234, 4'h5, 16'h1234, 4'h5},
        {1'b1, 2'b01, 16'h8003, 4'hA, 16'h8003, 4'hA},
        {1'b1, 2'b10, 16'h00FF, 4'h3, 16'h00FF, 4'h3}
    };

    function automatic string tag_of(input int idx);
        case (idx)
            0, 1, 2:     return "R3/R6/R7";
            3:           return "R8";
            4, 5, 6, 7:  return "R4/R7";
            8, 9, 10:    return "R5/R7";
            11:          return "R5/R8";
            12, 13, 14, 15: return "R9";
            16:          return "R10";
            default:     return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h cc=%h, expected res=%h cc=%h",
                     req, act[19:4], act[3:0], exp[19:4], exp[3:0]);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [1:0] op,
                         input logic [15:0] a, input logic [3:0] f);
        @(negedge clk);
        in_valid = v; wide_sel = w; op_sel = op; operand = a; cc_in = f;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; wide_sel = 1'b0; op_sel = 2'b00;
        operand = '0; cc_in = '0;
        repeat (3) @(negedge clk);
        check("R1", {result_q, cc_q}, 20'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC[i][42], VEC[i][41:40], VEC[i][39:24], VEC[i][23:20]);
            check(tag_of(i), {result_q, cc_q}, VEC[i][19:0]);
        end

        // R2: hold while in_valid is low, with inputs that would change the outputs
        drive(1'b1, 1'b0, 2'b01, 16'h0080, 4'h0);
        drive(1'b0, 1'b0, 2'b00, 16'h0003, 4'hF);
        check("R2", {result_q, cc_q}, {16'h00C0, 4'hA});
        drive(1'b0, 1'b1, 2'b00, 16'hFFFF, 4'h0);
        check("R2", {result_q, cc_q}, {16'h00C0, 4'hA});

        // R6/R7: rotate with old V set, new N and C both 1 -> V clear
        drive(1'b1, 1'b0, 2'b10, 16'h00FF, 4'h3);
        check("R7", {result_q, cc_q}, {16'h00FF, 4'h9});

        // R1: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R1", {result_q, cc_q}, 20'h0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule